// File: doc/BRIEF.md
# Programmable Parallel Port Interface

A register-mapped parallel I/O unit with three 8-bit ports, called A, B and C. A CPU-side bus reaches the three port data registers and a control register. The bus has a 2-bit address, a chip select, a read strobe and a write strobe. Port C is treated as two nibbles, and each nibble has its own direction. Every port brings out separate input, output and output-enable vectors, so no pad is modelled.

A control write has two uses. It can define the port directions and the port A operating mode. It can also set or clear a single port C bit and leave the other bits alone. Port A has two modes. In basic mode it is a plain port. In strobed-input mode, three port C pins carry the handshake: a strobe input, an input-buffer-full output and an interrupt-request output. In that mode, external data is captured on the strobe. A CPU read of port A then consumes the captured byte.

Bus accesses are sampled on the rising clock edge. A write takes effect at that edge. Read data is combinational from the current address and state. A port A read in strobed mode clears the handshake flags at the edge that ends the read cycle.

Top module: `ppio_unit`

## Requirements
- R1: Address decoding is 00 for port A, 01 for port B, 10 for port C and 11 for control. A write with sel and wr high loads the addressed register. A read of address 11 returns 0x00.
- R2: After reset, all ports are inputs and port A is in basic mode. All output latches are 0 and every output-enable bit is 0.
- R3: A control write with bit 7 = 1 is a mode word, and a direction bit of 1 makes that part an input. Bit 4 sets port A, bit 3 sets the C upper nibble, bit 1 sets port B and bit 0 sets the C lower nibble. An output part drives all of its enable bits to 1, and bit 2 has no effect.
- R4: A mode word clears the A, B and C output latches to 0. It also clears input-buffer-full, the interrupt request and the interrupt enable.
- R5: A control write with bit 7 = 0 changes exactly one port C latch bit. Bits 3-1 give the bit number, and bit 0 gives the new value (1 sets, 0 clears).
- R6: Port C bits 7-4 follow the upper-nibble direction, and bits 3-0 follow the lower-nibble direction, independently.
- R7: A read returns the output latch for each bit that is an output and the input pin for each bit that is an input.
- R8: Mode word bits 6-5 = 01 select strobed input on port A, and any other value selects basic. In strobed mode, port A is an input whatever bit 4 says. C bit 4 is the active-low strobe input, C bit 5 drives input-buffer-full and C bit 3 drives the interrupt request. Each of these three pins has a forced direction.
- R9: In strobed mode, each clock edge with the strobe low captures port A's input pins and sets input-buffer-full. A read of port A returns the captured byte.
- R10: The interrupt request is set on the first edge where the strobe is seen high again after being seen low, if the interrupt enable is 1. In strobed mode, a set/reset word that addresses bit 4 writes the interrupt enable.
- R11: A port A read in strobed mode clears input-buffer-full and the interrupt request. If the strobe is low in the same cycle, input-buffer-full stays set. If the strobe rises in the same cycle, the interrupt request is set.
- R12: rdata is 0x00 whenever sel and rd are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B input pins |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C input pins |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C output enables |

## Verification
Two things can happen in the same cycle: a CPU read of port A in strobed mode, and the external strobe handshake. The bench provokes two cases. In the first, it raises the strobe in the same cycle as the read. It then expects the read to return the byte captured earlier, the interrupt pin to end up high and the buffer-full pin to end up low. In the second, it holds the strobe low during the read. It then expects the old byte on the bus and the buffer-full pin to stay high, and a later read must return the newly captured byte.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int PORT_W  = 8;
  localparam int IDX_W   = $clog2(PORT_W);

  typedef enum logic [1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } ppio_sel_e;

  typedef enum logic {
    AMODE_BASIC  = 1'b0,
    AMODE_STROBE = 1'b1
  } ppio_amode_e;

  typedef struct packed {
    logic        a_in;
    logic        cu_in;
    logic        b_in;
    logic        cl_in;
    ppio_amode_e amode;
  } ppio_cfg_t;

  localparam ppio_cfg_t CFG_RESET = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1,
                                      cl_in: 1'b1, amode: AMODE_BASIC};

  // Mode word decode: fields passed separately so each is named at the call.
  function automatic ppio_cfg_t decode_mode(input logic [1:0] amode_bits,
                                            input logic a_dir, input logic cu_dir,
                                            input logic b_dir, input logic cl_dir);
    ppio_cfg_t c;
    c.a_in  = a_dir;
    c.cu_in = cu_dir;
    c.b_in  = b_dir;
    c.cl_in = cl_dir;
    c.amode = (amode_bits == 2'b01) ? AMODE_STROBE : AMODE_BASIC;
    return c;
  endfunction

  // Single-bit update of a latch.
  function automatic logic [PORT_W-1:0] bit_apply(input logic [PORT_W-1:0] cur,
                                                  input logic [IDX_W-1:0] idx,
                                                  input logic val);
    logic [PORT_W-1:0] r;
    r      = cur;
    r[idx] = val;
    return r;
  endfunction

  // Per-bit read selection: output bits show the latch, input bits the pin.
  function automatic logic [PORT_W-1:0] pick_read(input logic [PORT_W-1:0] pins,
                                                  input logic [PORT_W-1:0] drive,
                                                  input logic [PORT_W-1:0] oe);
    return (drive & oe) | (pins & ~oe);
  endfunction
endpackage

// File: rtl/ppio_latch.sv
module ppio_latch #(
  parameter int W = ppio_pkg::PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (clr)  q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
  import ppio_pkg::*;
#(
  parameter int W       = PORT_W,
  parameter int IW      = IDX_W,
  parameter int STB_BIT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_wr,
  input  logic         bsr_wr,
  input  logic         c_wr,
  input  logic [W-1:0] wdata,
  output ppio_cfg_t    cfg,
  output logic [W-1:0] pc_lat,
  output logic         inte
);
  logic [IW-1:0] bsr_idx;
  logic          bsr_val;
  logic          inte_hit;
  logic          unused_b_mode;

  assign bsr_idx       = wdata[IW:1];
  assign bsr_val       = wdata[0];
  assign inte_hit      = bsr_wr && (cfg.amode == AMODE_STROBE) && (bsr_idx == IW'(STB_BIT));
  assign unused_b_mode = wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else if (mode_wr) begin
      cfg <= decode_mode(wdata[6:5], wdata[4], wdata[3], wdata[1], wdata[0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_lat <= '0;
    else if (mode_wr) pc_lat <= '0;
    else if (bsr_wr)  pc_lat <= bit_apply(pc_lat, bsr_idx, bsr_val);
    else if (c_wr)    pc_lat <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        inte <= 1'b0;
    else if (mode_wr)  inte <= 1'b0;
    else if (inte_hit) inte <= bsr_val;
  end
endmodule

// File: rtl/ppio_strobe.sv
module ppio_strobe #(
  parameter int W = ppio_pkg::PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         clr,
  input  logic         stb_n,
  input  logic [W-1:0] din,
  input  logic         rd_clr,
  input  logic         inte,
  output logic [W-1:0] cap,
  output logic         ibf,
  output logic         irq,
  output logic         stb_low,
  output logic         stb_rise
);
  logic stb_prev;

  assign stb_low  = enable && !stb_n;
  assign stb_rise = enable && stb_n && !stb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_prev <= 1'b1;
    else        stb_prev <= stb_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap <= '0;
    else if (clr)     cap <= '0;
    else if (stb_low) cap <= din;
  end

  // Set beats clear: a new capture keeps the buffer marked full.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ibf <= 1'b0;
    else if (clr)     ibf <= 1'b0;
    else if (stb_low) ibf <= 1'b1;
    else if (rd_clr)  ibf <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irq <= 1'b0;
    else if (clr)              irq <= 1'b0;
    else if (stb_rise && inte) irq <= 1'b1;
    else if (rd_clr)           irq <= 1'b0;
  end
endmodule

// File: rtl/ppio_rdmux.sv
module ppio_rdmux
  import ppio_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic         a_strobed,
  input  logic [W-1:0] a_cap,
  input  logic [W-1:0] pa_in,
  input  logic [W-1:0] pa_lat,
  input  logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  input  logic [W-1:0] pb_lat,
  input  logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_in,
  input  logic [W-1:0] pc_drv,
  input  logic [W-1:0] pc_oe,
  output logic [W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (ppio_sel_e'(addr))
        SEL_A:    rdata = a_strobed ? a_cap : pick_read(pa_in, pa_lat, pa_oe);
        SEL_B:    rdata = pick_read(pb_in, pb_lat, pb_oe);
        SEL_C:    rdata = pick_read(pc_in, pc_drv, pc_oe);
        SEL_CTRL: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ppio_unit.sv
module ppio_unit
  import ppio_pkg::*;
#(
  parameter int W       = PORT_W,
  parameter int STB_BIT = 4,
  parameter int IBF_BIT = 5,
  parameter int IRQ_BIT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         rd,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);
  localparam int HALF = W / 2;

  // Named bus events, visible to the bound checker.
  logic acc_wr, acc_rd;
  logic a_wr, b_wr, c_wr, ctrl_wr;
  logic mode_wr, bsr_wr, rd_a_clr;
  logic a_strobed;
  ppio_cfg_t cfg;
  logic [W-1:0] pc_lat, a_cap;
  logic inte, ibf, irq, stb_low, stb_rise;
  logic [W-1:0] pc_oe_base;

  assign acc_wr    = sel && wr;
  assign acc_rd    = sel && rd;
  assign a_wr      = acc_wr && (ppio_sel_e'(addr) == SEL_A);
  assign b_wr      = acc_wr && (ppio_sel_e'(addr) == SEL_B);
  assign c_wr      = acc_wr && (ppio_sel_e'(addr) == SEL_C);
  assign ctrl_wr   = acc_wr && (ppio_sel_e'(addr) == SEL_CTRL);
  assign mode_wr   = ctrl_wr && wdata[W-1];
  assign bsr_wr    = ctrl_wr && !wdata[W-1];
  assign a_strobed = (cfg.amode == AMODE_STROBE);
  assign rd_a_clr  = acc_rd && (ppio_sel_e'(addr) == SEL_A) && a_strobed;

  ppio_ctrl #(.W(W), .IW($clog2(W)), .STB_BIT(STB_BIT)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .bsr_wr(bsr_wr), .c_wr(c_wr),
    .wdata(wdata), .cfg(cfg), .pc_lat(pc_lat), .inte(inte)
  );

  ppio_latch #(.W(W)) a_lat_i (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr), .load(a_wr), .din(wdata), .q(pa_out)
  );

  ppio_latch #(.W(W)) b_lat_i (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr), .load(b_wr), .din(wdata), .q(pb_out)
  );

  ppio_strobe #(.W(W)) stb_i (
    .clk(clk), .rst_n(rst_n), .enable(a_strobed), .clr(mode_wr),
    .stb_n(pc_in[STB_BIT]), .din(pa_in), .rd_clr(rd_a_clr), .inte(inte),
    .cap(a_cap), .ibf(ibf), .irq(irq), .stb_low(stb_low), .stb_rise(stb_rise)
  );

  assign pa_oe = (cfg.a_in || a_strobed) ? '0 : '1;
  assign pb_oe = cfg.b_in ? '0 : '1;
  assign pc_oe_base = {{(W-HALF){!cfg.cu_in}}, {HALF{!cfg.cl_in}}};

  // Handshake pins override the nibble directions in strobed mode.
  always_comb begin
    pc_oe  = pc_oe_base;
    pc_out = pc_lat;
    if (a_strobed) begin
      pc_oe[STB_BIT]  = 1'b0;
      pc_oe[IBF_BIT]  = 1'b1;
      pc_oe[IRQ_BIT]  = 1'b1;
      pc_out[IBF_BIT] = ibf;
      pc_out[IRQ_BIT] = irq;
    end
  end

  ppio_rdmux #(.W(W)) rdmux_i (
    .rd_en(acc_rd), .addr(addr), .a_strobed(a_strobed), .a_cap(a_cap),
    .pa_in(pa_in), .pa_lat(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_lat(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_drv(pc_out), .pc_oe(pc_oe),
    .rdata(rdata)
  );
endmodule

// File: rtl/ppio_checker.sv
module ppio_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel,
  input logic         rd,
  input logic         mode_wr,
  input logic         bsr_wr,
  input logic         rd_a_clr,
  input logic         stb_low,
  input logic         stb_rise,
  input logic         inte,
  input logic         ibf,
  input logic         irq,
  input logic [W-1:0] pc_lat,
  input logic [W-1:0] pa_out,
  input logic [W-1:0] pb_out,
  input logic [W-1:0] pa_oe,
  input logic [W-1:0] rdata
);
  assert_oe_uniform_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pa_oe) == 0) || ($countones(pa_oe) == W));

  assert_mode_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (pa_out == '0) && (pb_out == '0) && !ibf && !irq && !inte);

  assert_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_wr |=> ($countones(pc_lat ^ $past(pc_lat)) <= 1));

  assert_capture_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_low && !mode_wr) |=> ibf);

  assert_rise_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && inte && !mode_wr) |=> irq);

  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_clr && !stb_low && !stb_rise) |=> (!ibf && !irq));

  assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && rd) |-> (rdata == '0));
endmodule

bind ppio_unit ppio_checker #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .mode_wr(mode_wr),
  .bsr_wr(bsr_wr), .rd_a_clr(rd_a_clr), .stb_low(stb_low), .stb_rise(stb_rise),
  .inte(inte), .ibf(ibf), .irq(irq), .pc_lat(pc_lat), .pa_out(pa_out),
  .pb_out(pb_out), .pa_oe(pa_oe), .rdata(rdata)
);

// File: tb/ppio_unit_tb_top.sv
module ppio_unit_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h5A, pb_in = 8'hA5, pc_in = 8'h1F;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  ppio_unit dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares every read cycle against the queue.
  always @(negedge clk) begin
    #2;
    if (sel && rd) begin
      if (exp_q.size() == 0) begin
        chk(32'(rdata), 32'hFFFF_FFFF, "R1 unexpected read");
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(32'(rdata), 32'(e), t);
      end
    end else if (!done && rst_n) begin
      chk(32'(rdata), 32'h0, "R12 idle rdata");
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    sel = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    sel = 1'b0; rd = 1'b0;
  endtask

  // One-cycle low strobe followed by one cycle high.
  task automatic strobe_pulse(input logic [7:0] d);
    pa_in = d; pc_in[4] = 1'b0;
    @(negedge clk);
    pc_in[4] = 1'b1; pa_in = 8'hEE;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk({8'h0, pa_oe, pb_oe, pc_oe}, 32'h0, "R2 reset enables");
    chk({8'h0, pa_out, pb_out, pc_out}, 32'h0, "R2 reset latches");
    bus_rd(2'b00, 8'h5A, "R7 A input pins");
    bus_rd(2'b01, 8'hA5, "R1 B input pins");
    bus_rd(2'b10, 8'h1F, "R6 C input pins");
    bus_rd(2'b11, 8'h00, "R1 control read zero");

    bus_wr(2'b11, 8'h80);
    chk({8'h0, pa_oe, pb_oe, pc_oe}, 32'h00FF_FFFF, "R3 all outputs");
    bus_wr(2'b00, 8'h3C);
    bus_wr(2'b01, 8'hC3);
    bus_wr(2'b10, 8'h81);
    chk({16'h0, pa_out, pb_out}, 32'h3CC3, "R1 port latches");
    bus_rd(2'b00, 8'h3C, "R7 A latch readback");
    bus_rd(2'b01, 8'hC3, "R7 B latch readback");
    bus_rd(2'b10, 8'h81, "R7 C latch readback");

    bus_wr(2'b11, 8'h05);
    bus_rd(2'b10, 8'h85, "R5 set bit 2");
    bus_wr(2'b11, 8'h0E);
    bus_rd(2'b10, 8'h05, "R5 clear bit 7");
    chk(32'(pc_out), 32'h05, "R5 pins after set/reset");

    bus_wr(2'b11, 8'h88);
    chk({16'h0, pa_out, pb_out}, 32'h0, "R4 latches cleared");
    chk(32'(pc_oe), 32'h0F, "R6 upper nibble input");
    bus_rd(2'b10, 8'h10, "R6 upper pins lower latch");
    bus_wr(2'b11, 8'h81);
    chk(32'(pc_oe), 32'hF0, "R6 lower nibble input");
    bus_rd(2'b10, 8'h0F, "R6 lower pins upper latch");

    bus_wr(2'b11, 8'h96);
    chk({16'h0, pa_oe, pb_oe}, 32'h0, "R3 A and B input, bit 2 ignored");
    bus_rd(2'b01, 8'hA5, "R3 B input read");

    bus_wr(2'b11, 8'hA0);
    chk({16'h0, pa_oe, pc_oe}, 32'h00EF, "R8 strobed directions");
    chk(32'({pc_out[5], pc_out[3]}), 32'h0, "R8 handshake idle");
    bus_wr(2'b11, 8'h09);
    strobe_pulse(8'h77);
    chk(32'(pc_out[5]), 32'h1, "R9 buffer full");
    chk(32'(pc_out[3]), 32'h1, "R10 irq raised");
    bus_rd(2'b00, 8'h77, "R9 captured byte");
    chk(32'({pc_out[5], pc_out[3]}), 32'h0, "R11 read clears");

    bus_wr(2'b11, 8'h08);
    strobe_pulse(8'h22);
    chk(32'({pc_out[5], pc_out[3]}), 32'h2, "R10 irq gated off");
    bus_rd(2'b00, 8'h22, "R9 second capture");

    bus_wr(2'b11, 8'h09);
    pa_in = 8'h33; pc_in[4] = 1'b0;
    @(negedge clk);
    pc_in[4] = 1'b1; pa_in = 8'hEE;
    bus_rd(2'b00, 8'h33, "R11 read on rise");
    chk(32'({pc_out[5], pc_out[3]}), 32'h1, "R11 rise beats read clear");

    pa_in = 8'h44; pc_in[4] = 1'b0;
    bus_rd(2'b00, 8'h33, "R11 read during low strobe");
    pc_in[4] = 1'b1; pa_in = 8'hEE;
    @(negedge clk);
    chk(32'(pc_out[5]), 32'h1, "R11 capture beats read clear");
    bus_rd(2'b00, 8'h44, "R9 byte from overlapped capture");

    bus_wr(2'b11, 8'h9B);
    chk({16'h0, pc_oe, 7'h0, pc_out[5]}, 32'h0, "R4 strobed state cleared");

    @(negedge clk);
    chk(32'(exp_q.size()), 32'h0, "R1 scoreboard drained");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule